// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Port

This block lets a processor run three-wire serial EEPROMs purely in software. Each register write sets the chip-select, clock and data-in levels of one EEPROM. Each register read returns that EEPROM's data-out level. Software builds every command, address and data frame by toggling these pins one write at a time. The block only decodes the pin fields, steers them to the right device and keeps every other device quiet.

One mainboard EEPROM and a set of module-slot EEPROMs (slots 0 to 6 by default) are attached. A static `big_chassis` input picks one of two register layouts.

- **Small layout:** one mainboard port and one shared module port. The shared port carries a 2-bit slot-select field in the same write that moves the pins.
- **Large layout:** a backplane (mainboard) port plus one dedicated port per module slot. A read of the backplane port always reports an enterprise chassis.

The two kinds of port place the same signals at different bit positions.

Top module: `eeprom_bb_port`

## Requirements
- R1: After reset, every chip-select, clock and data-in output is low, and the shared module port selects slot 0.
- R2: A write to the mainboard port drives the mainboard pins from the written data one clock edge later: chip select from bit 0, clock from bit 1, data-in from bit 2. The mainboard port is offset 0x0000e in small layout and 0x10000 in large layout.
- R3: In small layout, a read of offset 0x0000e returns the mainboard data-out level in bit 3, with all other bits zero. Reads are combinational in the same cycle.
- R4: In small layout, a write to offset 0x10008 takes bits 1:0 as the new slot. In that same write, the newly selected slot's pins are set: chip select from bit 4, clock from bit 2, data-in from bit 6. Bits other than 1:0, 2, 4 and 6 have no effect.
- R5: At any time, at most one module slot has any of chip select, clock or data-in high. Every module write drives all non-addressed slots to chip select, clock and data-in low.
- R6: In small layout, a read of offset 0x10008 returns the data-out level of the currently selected slot in bit 7, with all other bits zero.
- R7: In large layout, a write to offset 0x1000a + k (k = 0..5) drives slot k+1, and a write to offset 0x20006 drives slot 0. Both use the module bit positions of R4.
- R8: In large layout, a read of offset 0x10000 returns the mainboard data-out level in bit 3 and always has bit 7 set.
- R9: In large layout, a read of a dedicated slot offset returns that slot's data-out level in bit 7, with all other bits zero.
- R10: An offset that is not a port in the current layout is ignored. A write there changes no pin, and a read returns zero. This includes 0x10008 and 0x0000e in large layout, 0x10000 and 0x1000a to 0x1000f in small layout, and 0x10010.
- R11: Pins change only on a write to their own port. A mainboard write leaves every module pin unchanged, and a module write leaves the mainboard pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_chassis | input | 1 | 0 selects the small layout, 1 the large layout |
| reg_addr | input | 20 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write enable, sampled at the clock edge |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| mb_cs | output | 1 | Mainboard EEPROM chip select |
| mb_sk | output | 1 | Mainboard EEPROM serial clock |
| mb_di | output | 1 | Mainboard EEPROM data toward the device |
| mb_do | input | 1 | Mainboard EEPROM data from the device |
| mod_cs | output | 7 | Module EEPROM chip selects, one per slot |
| mod_sk | output | 7 | Module EEPROM serial clocks, one per slot |
| mod_di | output | 7 | Module EEPROM data toward each device |
| mod_do | input | 7 | Module EEPROM data from each device |

## Verification
Every pin output is a register. A write accepted at one rising edge shows on the pins just after that edge and holds until the next accepted write. Read data depends only on the offset, the layout input, the data-out inputs and the stored slot, so it is valid in the same cycle the offset is presented.

The bench drives inputs on the falling edge. It checks pins at the falling edge that follows the write's rising edge, and checks read data 2 ns after setting the offset, with no clock edge in between. The ignore cases are judged by re-reading every pin after the stray write.

// File: rtl/eeprom_bb_pkg.sv
package eeprom_bb_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 2;

    // small layout
    localparam logic [ADDR_W-1:0] SM_MB_OFS    = 20'h0000e;
    localparam logic [ADDR_W-1:0] SM_MOD_OFS   = 20'h10008;
    // large layout
    localparam logic [ADDR_W-1:0] LG_MB_OFS    = 20'h10000;
    localparam logic [ADDR_W-1:0] LG_DIR_BASE  = 20'h1000a;
    localparam logic [ADDR_W-1:0] LG_SLOT0_OFS = 20'h20006;

    // mainboard field positions
    localparam int MB_CS_B  = 0;
    localparam int MB_SK_B  = 1;
    localparam int MB_DI_B  = 2;
    localparam int MB_DO_B  = 3;
    // module field positions
    localparam int MOD_CS_B = 4;
    localparam int MOD_SK_B = 2;
    localparam int MOD_DI_B = 6;
    localparam int MOD_DO_B = 7;
    // enterprise flag on backplane reads
    localparam int BP_FLAG_B = 7;

    typedef enum logic [1:0] {
        P_NONE,
        P_MB,
        P_SHARED,
        P_DIRECT
    } port_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    function automatic pins_t mb_fields(input logic [DATA_W-1:0] d);
        pins_t p;
        p.cs = d[MB_CS_B];
        p.sk = d[MB_SK_B];
        p.di = d[MB_DI_B];
        return p;
    endfunction

    function automatic pins_t mod_fields(input logic [DATA_W-1:0] d);
        pins_t p;
        p.cs = d[MOD_CS_B];
        p.sk = d[MOD_SK_B];
        p.di = d[MOD_DI_B];
        return p;
    endfunction

endpackage

// File: rtl/eeprom_bb_decode.sv
module eeprom_bb_decode
    import eeprom_bb_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int SLOT_W    = 3
) (
    input  logic              big_chassis,
    input  logic [ADDR_W-1:0] addr,
    output port_e             tgt,
    output logic [SLOT_W-1:0] dslot
);

    logic [ADDR_W-1:0] rel;

    assign rel = addr - LG_DIR_BASE;

    always_comb begin
        tgt   = P_NONE;
        dslot = '0;
        if (!big_chassis) begin
            if (addr == SM_MB_OFS) begin
                tgt = P_MB;
            end else if (addr == SM_MOD_OFS) begin
                tgt = P_SHARED;
            end
        end else begin
            if (addr == LG_MB_OFS) begin
                tgt = P_MB;
            end else if (addr == LG_SLOT0_OFS) begin
                tgt   = P_DIRECT;
                dslot = '0;
            end else if (rel < ADDR_W'(NUM_SLOTS - 1)) begin
                tgt   = P_DIRECT;
                dslot = SLOT_W'(rel + 1'b1);
            end
        end
    end

endmodule

// File: rtl/eeprom_bb_bank.sv
module eeprom_bb_bank
    import eeprom_bb_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  pins_t                wr_pins,
    output logic [NUM_SLOTS-1:0] cs,
    output logic [NUM_SLOTS-1:0] sk,
    output logic [NUM_SLOTS-1:0] di
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        pins_t q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en) begin
                if (wr_slot == SLOT_W'(i)) begin
                    q <= wr_pins;
                end else begin
                    q <= '0;
                end
            end
        end

        assign cs[i] = q.cs;
        assign sk[i] = q.sk;
        assign di[i] = q.di;
    end

endmodule

// File: rtl/eeprom_bb_port.sv
module eeprom_bb_port
    import eeprom_bb_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int SLOT_W   = (NUM_SLOTS > 4) ? $clog2(NUM_SLOTS) : 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 big_chassis,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_we,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 mb_cs,
    output logic                 mb_sk,
    output logic                 mb_di,
    input  logic                 mb_do,
    output logic [NUM_SLOTS-1:0] mod_cs,
    output logic [NUM_SLOTS-1:0] mod_sk,
    output logic [NUM_SLOTS-1:0] mod_di,
    input  logic [NUM_SLOTS-1:0] mod_do
);

    port_e             tgt;
    logic [SLOT_W-1:0] dslot;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic              wr_mb_hit;
    logic              wr_mod_hit;
    logic              rd_mod_bit;
    pins_t             mb_q;
    logic              unused_wdata;

    eeprom_bb_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .big_chassis (big_chassis),
        .addr        (reg_addr),
        .tgt         (tgt),
        .dslot       (dslot)
    );

    assign wr_mb_hit  = reg_we && (tgt == P_MB);
    assign wr_mod_hit = reg_we && ((tgt == P_SHARED) || (tgt == P_DIRECT));
    assign wr_slot    = (tgt == P_SHARED) ? SLOT_W'(reg_wdata[SEL_W-1:0]) : dslot;

    // selected slot for the shared port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (wr_mod_hit) begin
            slot_q <= wr_slot;
        end
    end

    // mainboard pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_q <= '0;
        end else if (wr_mb_hit) begin
            mb_q <= mb_fields(reg_wdata);
        end
    end

    assign mb_cs = mb_q.cs;
    assign mb_sk = mb_q.sk;
    assign mb_di = mb_q.di;

    eeprom_bb_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_mod_hit),
        .wr_slot (wr_slot),
        .wr_pins (mod_fields(reg_wdata)),
        .cs      (mod_cs),
        .sk      (mod_sk),
        .di      (mod_di)
    );

    // read path
    assign rd_slot    = (tgt == P_SHARED) ? slot_q : dslot;
    assign rd_mod_bit = (int'(rd_slot) < NUM_SLOTS) ? mod_do[rd_slot] : 1'b0;

    always_comb begin
        reg_rdata = '0;
        unique case (tgt)
            P_MB: begin
                reg_rdata[MB_DO_B]   = mb_do;
                reg_rdata[BP_FLAG_B] = big_chassis;
            end
            P_SHARED, P_DIRECT: begin
                reg_rdata[MOD_DO_B] = rd_mod_bit;
            end
            default: begin
                reg_rdata = '0;
            end
        endcase
    end

    assign unused_wdata = ^{reg_wdata[DATA_W-1:8], reg_wdata[7], reg_wdata[5], reg_wdata[3]};

endmodule

// File: rtl/eeprom_bb_chk.sv
module eeprom_bb_chk
    import eeprom_bb_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 big_chassis,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 reg_we,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 mb_cs,
    input logic                 mb_sk,
    input logic                 mb_di,
    input logic [NUM_SLOTS-1:0] mod_cs,
    input logic [NUM_SLOTS-1:0] mod_sk,
    input logic [NUM_SLOTS-1:0] mod_di,
    input logic                 wr_mb_hit,
    input logic                 wr_mod_hit
);

    logic [NUM_SLOTS-1:0] active;
    logic                 unused_chk;

    assign active     = mod_cs | mod_sk | mod_di;
    assign unused_chk = ^reg_wdata;

    a_r2_mb_pins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mb_hit |=> {mb_cs, mb_sk, mb_di} == $past({reg_wdata[0], reg_wdata[1], reg_wdata[2]}));

    a_r4_shared_select: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !big_chassis && reg_addr == SM_MOD_OFS)
        |=> mod_cs[$past(reg_wdata[1:0])] == $past(reg_wdata[4]));

    a_r5_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));

    a_r7_direct_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && big_chassis && reg_addr == LG_DIR_BASE)
        |=> mod_cs[1] == $past(reg_wdata[4]));

    a_r8_enterprise_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (big_chassis && reg_addr == LG_MB_OFS) |-> reg_rdata[7]);

    a_r11_mb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mb_hit |=> $stable({mb_cs, mb_sk, mb_di}));

    a_r11_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mod_hit |=> $stable({mod_cs, mod_sk, mod_di}));

endmodule

bind eeprom_bb_port eeprom_bb_chk #(
    .NUM_SLOTS (NUM_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .big_chassis (big_chassis),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .mb_cs       (mb_cs),
    .mb_sk       (mb_sk),
    .mb_di       (mb_di),
    .mod_cs      (mod_cs),
    .mod_sk      (mod_sk),
    .mod_di      (mod_di),
    .wr_mb_hit   (wr_mb_hit),
    .wr_mod_hit  (wr_mod_hit)
);

// File: tb/test_eeprom_bb_port.sv
`timescale 1ns/1ps
module test_eeprom_bb_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_chassis = 1'b0;
    logic [19:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        mb_cs, mb_sk, mb_di;
    logic        mb_do = 1'b0;
    logic [6:0]  mod_cs, mod_sk, mod_di;
    logic [6:0]  mod_do = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    eeprom_bb_port i_eeprom_bb_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .big_chassis (big_chassis),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata),
        .mb_cs       (mb_cs),
        .mb_sk       (mb_sk),
        .mb_di       (mb_di),
        .mb_do       (mb_do),
        .mod_cs      (mod_cs),
        .mod_sk      (mod_sk),
        .mod_di      (mod_di),
        .mod_do      (mod_do)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input logic [2:0] e_mb,
                            input logic [6:0] e_cs, input logic [6:0] e_sk,
                            input logic [6:0] e_di);
        chk({tag, " mb{cs,sk,di}"}, {29'd0, mb_cs, mb_sk, mb_di}, {29'd0, e_mb});
        chk({tag, " mod_cs"}, {25'd0, mod_cs}, {25'd0, e_cs});
        chk({tag, " mod_sk"}, {25'd0, mod_sk}, {25'd0, e_sk});
        chk({tag, " mod_di"}, {25'd0, mod_di}, {25'd0, e_di});
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [19:0] a, input logic [15:0] e);
        @(negedge clk);
        reg_addr = a;
        #2;
        chk(tag, {16'd0, reg_rdata}, {16'd0, e});
    endtask

    task automatic t_reset;
        chk_pins("R1 reset pins", 3'b000, 7'd0, 7'd0, 7'd0);
        mod_do = 7'b0000001;
        rd_chk("R1 reset selects slot 0", 20'h10008, 16'h0080);
        mod_do = 7'b1111110;
        rd_chk("R1 R6 slot 0 low", 20'h10008, 16'h0000);
    endtask

    task automatic t_small_mb;
        big_chassis = 1'b0;
        wr(20'h0000e, 16'h0007);
        chk_pins("R2 R11 mb all high", 3'b111, 7'd0, 7'd0, 7'd0);
        wr(20'h0000e, 16'hFFF5);
        chk_pins("R2 mb cs,di", 3'b101, 7'd0, 7'd0, 7'd0);
        mb_do = 1'b1;
        rd_chk("R3 mb do=1", 20'h0000e, 16'h0008);
        mb_do = 1'b0;
        rd_chk("R3 mb do=0", 20'h0000e, 16'h0000);
    endtask

    task automatic t_small_mod;
        big_chassis = 1'b0;
        wr(20'h10008, 16'h0052);
        chk_pins("R4 slot2 cs,di", 3'b101, 7'b0000100, 7'd0, 7'b0000100);
        wr(20'h10008, 16'h0056);
        chk_pins("R4 slot2 clock", 3'b101, 7'b0000100, 7'b0000100, 7'b0000100);
        wr(20'h10008, 16'h0015);
        chk_pins("R4 R5 R11 switch to slot1", 3'b101, 7'b0000010, 7'b0000010, 7'd0);
        mod_do = 7'b0000010;
        rd_chk("R6 slot1 do=1", 20'h10008, 16'h0080);
        mod_do = 7'b0000100;
        rd_chk("R6 slot1 do=0", 20'h10008, 16'h0000);
        wr(20'h10008, 16'hFF13);
        chk_pins("R4 upper bits ignored slot3", 3'b101, 7'b0001000, 7'd0, 7'd0);
        mod_do = 7'b0001000;
        rd_chk("R6 slot3 do=1", 20'h10008, 16'h0080);
    endtask

    task automatic t_big_mod;
        big_chassis = 1'b1;
        wr(20'h1000c, 16'h0054);
        chk_pins("R7 direct slot3", 3'b101, 7'b0001000, 7'b0001000, 7'b0001000);
        wr(20'h20006, 16'h0010);
        chk_pins("R7 R5 slot0 port", 3'b101, 7'b0000001, 7'd0, 7'd0);
        wr(20'h1000f, 16'h0014);
        chk_pins("R7 direct slot6", 3'b101, 7'b1000000, 7'b1000000, 7'd0);
        mod_do = 7'b0010000;
        rd_chk("R9 slot4 do=1", 20'h1000d, 16'h0080);
        mod_do = 7'b1101111;
        rd_chk("R9 slot4 do=0", 20'h1000d, 16'h0000);
        mod_do = 7'b0000001;
        rd_chk("R9 slot0 do=1", 20'h20006, 16'h0080);
    endtask

    task automatic t_big_mb;
        big_chassis = 1'b1;
        wr(20'h10000, 16'h0003);
        chk_pins("R2 R11 backplane write", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        mb_do = 1'b0;
        rd_chk("R8 flag do=0", 20'h10000, 16'h0080);
        mb_do = 1'b1;
        rd_chk("R8 flag do=1", 20'h10000, 16'h0088);
    endtask

    task automatic t_unmapped;
        big_chassis = 1'b1;
        wr(20'h10008, 16'h0057);
        chk_pins("R10 large 0x10008 write", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        wr(20'h0000e, 16'h0004);
        chk_pins("R10 large 0x0000e write", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        wr(20'h10010, 16'hFFFF);
        chk_pins("R10 past direct range", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        mb_do = 1'b1;
        rd_chk("R10 large 0x0000e read", 20'h0000e, 16'h0000);
        big_chassis = 1'b0;
        wr(20'h1000a, 16'h0014);
        chk_pins("R10 small 0x1000a write", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        wr(20'h10000, 16'h0000);
        chk_pins("R10 small 0x10000 write", 3'b110, 7'b1000000, 7'b1000000, 7'd0);
        mod_do = 7'b1111111;
        rd_chk("R10 small 0x10000 read", 20'h10000, 16'h0000);
        rd_chk("R10 small 0x1000b read", 20'h1000b, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_mb();
        t_small_mod();
        t_big_mod();
        t_big_mb();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule